// File: doc/BRIEF.md
# Single-Cycle Load-Store RISC Core

This block is a 32-bit processor core that fetches, decodes, executes and retires one instruction in every clock cycle. It handles a small instruction set: word load, word store, five register-to-register operations (add, subtract, AND, OR, signed set-on-less-than), a branch taken when two registers are equal, and an unconditional jump. The core holds the program counter, a 32-entry register file, the ALU, the sign extender, and the instruction and data memories.

Control is split into two levels. The opcode decoder sorts each instruction into one of six classes: R-type, load, store, branch, jump and no-op. It then drives a fixed set of datapath selects and a 2-bit ALU request. A second decoder combines that request with the function field to choose a 4-bit ALU operation. The only sequential state is the program-counter register. All datapath decisions are made combinationally inside one cycle, so the next-PC multiplexer takes one of three named transitions: sequential, branch or jump.

Before execution starts, the memories are filled through a loading port while reset is held. The retirement of each instruction can be seen on two commit ports. One reports register writebacks and the other reports memory stores. An instruction drives them in the same cycle it executes.

Top module: `onecyc_core`

## Requirements
- R1: While `rst` is high at a clock edge the PC becomes 0, and no register or data-memory write happens; the commit ports stay low. After release, the first instruction executed is the word at byte address 0.
- R2: Instruction fields are opcode [31:26], rs [25:21], rt [20:16], rd [15:11], shamt [10:6], funct [5:0], immediate [15:0] (sign-extended), jump index [25:0]. Opcodes are R-type 000000, load 100011, store 101011, branch-equal 000100 and jump 000010.
- R3: With opcode 000000, funct 100000 writes rs+rt, 100010 writes rs-rt, 100100 writes rs AND rt, and 100101 writes rs OR rt into rd. The shamt field has no effect. Internally the ALU codes are AND 0000, OR 0001, add 0010, subtract 0110, set-less-than 0111 and NOR 1100.
- R4: Funct 101010 writes 1 into rd when rs is less than rt as signed 32-bit numbers, and 0 otherwise.
- R5: A load writes into rt the data word at word index (rs + sext(imm))[7:2]. A negative displacement works.
- R6: A store writes rt into the data word at byte address rs + sext(imm). It also reports that address and that value on the store commit port.
- R7: A branch-equal with rs == rt sets the PC to PC+4 + (sext(imm) << 2), and backward targets also work. When rs != rt the PC becomes PC+4. A branch writes no register.
- R8: A jump sets the PC to {PC+4[31:28], index, 2'b00} and writes nothing.
- R9: Register 0 always reads as 0. A write aimed at it is dropped and is not reported on the writeback commit port.
- R10: Any other opcode writes neither a register nor memory, and the PC advances by 4.
- R11: `wb_en_o` is high in exactly those cycles in which the executing instruction writes a nonzero register, with its index and value. `st_en_o` is high exactly in store cycles.
- R12: A loading-port write on a clock edge fills the instruction word (`ld_dmem`=0) or data word (`ld_dmem`=1) at word index `ld_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ld_en | input | 1 | Loading-port write strobe |
| ld_dmem | input | 1 | Loading-port target: 0 instruction memory, 1 data memory |
| ld_addr | input | 32 | Loading-port word index |
| ld_data | input | 32 | Loading-port word |
| pc_o | output | 32 | Current program counter (byte address) |
| wb_en_o | output | 1 | Register writeback in this cycle |
| wb_idx_o | output | 5 | Written register index |
| wb_val_o | output | 32 | Written value |
| st_en_o | output | 1 | Memory store in this cycle |
| st_addr_o | output | 32 | Store byte address |
| st_val_o | output | 32 | Stored word |

## Verification
The ports show only retired effects, so the hard parts are the instructions that should leave no trace: skipped words after a taken branch or jump, a write aimed at register 0, and an undefined opcode. The program places marker instructions in every shadow slot, and each marker would produce a writeback. The scoreboard expects an exact ordered list of writebacks and stores, so any shadow instruction that executes shows up as an unexpected or out-of-order event. The run ends in a backward self-branch, and a stable final PC confirms that the backward target was taken.

// File: rtl/onecyc_pkg.sv
`timescale 1ns/1ps
package onecyc_pkg;

    localparam logic [5:0] OPC_RTYPE = 6'b000000;
    localparam logic [5:0] OPC_JUMP  = 6'b000010;
    localparam logic [5:0] OPC_BEQ   = 6'b000100;
    localparam logic [5:0] OPC_LOAD  = 6'b100011;
    localparam logic [5:0] OPC_STORE = 6'b101011;

    localparam logic [5:0] FN_ADD = 6'b100000;
    localparam logic [5:0] FN_SUB = 6'b100010;
    localparam logic [5:0] FN_AND = 6'b100100;
    localparam logic [5:0] FN_OR  = 6'b100101;
    localparam logic [5:0] FN_SLT = 6'b101010;

    typedef enum logic [1:0] {
        AOP_ADD   = 2'b00,
        AOP_SUB   = 2'b01,
        AOP_FUNCT = 2'b10
    } aluop_e;

    typedef enum logic [3:0] {
        ALU_AND = 4'b0000,
        ALU_OR  = 4'b0001,
        ALU_ADD = 4'b0010,
        ALU_SUB = 4'b0110,
        ALU_SLT = 4'b0111,
        ALU_NOR = 4'b1100
    } aluctl_e;

    typedef enum logic [2:0] {
        CLS_RTYPE,
        CLS_LOAD,
        CLS_STORE,
        CLS_BRANCH,
        CLS_JUMP,
        CLS_NOP
    } iclass_e;

    typedef struct packed {
        logic   dst_rd;
        logic   src_imm;
        logic   wb_mem;
        logic   reg_we;
        logic   mem_re;
        logic   mem_we;
        logic   branch;
        logic   jump;
        aluop_e aop;
    } ctrl_t;

endpackage

// File: rtl/onecyc_ctrl_dec.sv
`timescale 1ns/1ps
module onecyc_ctrl_dec
    import onecyc_pkg::*;
(
    input  logic [5:0] opcode,
    output ctrl_t      ctrl,
    output iclass_e    cls
);
    always_comb begin
        ctrl     = '0;
        ctrl.aop = AOP_ADD;
        cls      = CLS_NOP;
        unique case (opcode)
            OPC_RTYPE: begin
                cls         = CLS_RTYPE;
                ctrl.dst_rd = 1'b1;
                ctrl.reg_we = 1'b1;
                ctrl.aop    = AOP_FUNCT;
            end
            OPC_LOAD: begin
                cls          = CLS_LOAD;
                ctrl.src_imm = 1'b1;
                ctrl.wb_mem  = 1'b1;
                ctrl.reg_we  = 1'b1;
                ctrl.mem_re  = 1'b1;
            end
            OPC_STORE: begin
                cls          = CLS_STORE;
                ctrl.src_imm = 1'b1;
                ctrl.mem_we  = 1'b1;
            end
            OPC_BEQ: begin
                cls         = CLS_BRANCH;
                ctrl.branch = 1'b1;
                ctrl.aop    = AOP_SUB;
            end
            OPC_JUMP: begin
                cls       = CLS_JUMP;
                ctrl.jump = 1'b1;
            end
            default: cls = CLS_NOP;
        endcase
    end
endmodule

// File: rtl/onecyc_alu_dec.sv
`timescale 1ns/1ps
module onecyc_alu_dec
    import onecyc_pkg::*;
(
    input  aluop_e     aop,
    input  logic [5:0] funct,
    output aluctl_e    op
);
    always_comb begin
        op = ALU_ADD;
        unique case (aop)
            AOP_ADD: op = ALU_ADD;
            AOP_SUB: op = ALU_SUB;
            AOP_FUNCT: begin
                unique case (funct)
                    FN_ADD:  op = ALU_ADD;
                    FN_SUB:  op = ALU_SUB;
                    FN_AND:  op = ALU_AND;
                    FN_OR:   op = ALU_OR;
                    FN_SLT:  op = ALU_SLT;
                    default: op = ALU_ADD;
                endcase
            end
            default: op = ALU_ADD;
        endcase
    end
endmodule

// File: rtl/onecyc_alu.sv
`timescale 1ns/1ps
module onecyc_alu
    import onecyc_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  aluctl_e      op,
    output logic [W-1:0] y,
    output logic         zero
);
    always_comb begin
        unique case (op)
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
            ALU_NOR: y = ~(a | b);
            default: y = a + b;
        endcase
    end
    assign zero = (y == '0);
endmodule

// File: rtl/onecyc_regfile.sv
`timescale 1ns/1ps
module onecyc_regfile #(
    parameter int W = 32,
    parameter int N = 32,
    localparam int AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] ra,
    input  logic [AW-1:0] rb,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [W-1:0]  wd,
    output logic [W-1:0]  rda,
    output logic [W-1:0]  rdb
);
    logic [W-1:0] regs [N];

    always_ff @(posedge clk) begin
        if (we && wa != '0) regs[wa] <= wd;
    end

    assign rda = (ra == '0) ? '0 : regs[ra];
    assign rdb = (rb == '0) ? '0 : regs[rb];

    // R11: an accepted write is readable from the array on the next cycle
    assert_wr_stored_R11: assert property (@(posedge clk) disable iff (rst)
        (we && wa != '0) |=> (regs[$past(wa)] == $past(wd)));
endmodule

// File: rtl/onecyc_core.sv
`timescale 1ns/1ps
module onecyc_core
    import onecyc_pkg::*;
#(
    parameter int IMEM_WORDS = 64,
    parameter int DMEM_WORDS = 64,
    parameter int NREGS      = 32
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        ld_en,
    input  logic        ld_dmem,
    input  logic [31:0] ld_addr,
    input  logic [31:0] ld_data,
    output logic [31:0] pc_o,
    output logic        wb_en_o,
    output logic [4:0]  wb_idx_o,
    output logic [31:0] wb_val_o,
    output logic        st_en_o,
    output logic [31:0] st_addr_o,
    output logic [31:0] st_val_o
);
    localparam int IAW = $clog2(IMEM_WORDS);
    localparam int DAW = $clog2(DMEM_WORDS);
    localparam int RAW = $clog2(NREGS);

    logic [31:0] imem [IMEM_WORDS];
    logic [31:0] dmem [DMEM_WORDS];

    logic [31:0] pc_q, pc_next, pc_plus4, br_target, j_target;
    logic [31:0] instr, sext, rd_a, rd_b, alu_b, alu_y, load_word, wb_data;
    logic [RAW-1:0] wr_idx;
    logic        alu_zero, rf_we;
    ctrl_t       ctrl;
    iclass_e     cls;
    aluctl_e     alu_op;

    // Program-counter register: the only state of the control path
    always_ff @(posedge clk) begin
        if (rst) pc_q <= '0;
        else     pc_q <= pc_next;
    end

    assign instr     = imem[pc_q[IAW+1:2]];
    assign pc_plus4  = pc_q + 32'd4;
    assign sext      = {{16{instr[15]}}, instr[15:0]};
    assign br_target = pc_plus4 + {sext[29:0], 2'b00};
    assign j_target  = {pc_plus4[31:28], instr[25:0], 2'b00};

    // Next-PC transitions: jump, taken branch, sequential
    always_comb begin
        if (ctrl.jump)                      pc_next = j_target;
        else if (ctrl.branch && alu_zero)   pc_next = br_target;
        else                                pc_next = pc_plus4;
    end

    onecyc_ctrl_dec u_ctrl (.opcode(instr[31:26]), .ctrl(ctrl), .cls(cls));
    onecyc_alu_dec  u_adec (.aop(ctrl.aop), .funct(instr[5:0]), .op(alu_op));

    assign wr_idx = ctrl.dst_rd ? instr[15:11] : instr[20:16];
    assign rf_we  = ctrl.reg_we && !rst;

    onecyc_regfile #(.W(32), .N(NREGS)) u_rf (
        .clk(clk), .rst(rst),
        .ra(instr[25:21]), .rb(instr[20:16]),
        .we(rf_we), .wa(wr_idx), .wd(wb_data),
        .rda(rd_a), .rdb(rd_b)
    );

    assign alu_b = ctrl.src_imm ? sext : rd_b;

    onecyc_alu #(.W(32)) u_alu (.a(rd_a), .b(alu_b), .op(alu_op), .y(alu_y), .zero(alu_zero));

    assign load_word = ctrl.mem_re ? dmem[alu_y[DAW+1:2]] : '0;
    assign wb_data   = ctrl.wb_mem ? load_word : alu_y;

    // Memories: loading port has priority; stores only out of reset
    always_ff @(posedge clk) begin
        if (ld_en) begin
            if (ld_dmem) dmem[ld_addr[DAW-1:0]] <= ld_data;
            else         imem[ld_addr[IAW-1:0]] <= ld_data;
        end else if (!rst && ctrl.mem_we) begin
            dmem[alu_y[DAW+1:2]] <= rd_b;
        end
    end

    assign pc_o      = pc_q;
    assign wb_en_o   = rf_we && (wr_idx != '0);
    assign wb_idx_o  = wr_idx;
    assign wb_val_o  = wb_data;
    assign st_en_o   = ctrl.mem_we && !rst;
    assign st_addr_o = alu_y;
    assign st_val_o  = rd_b;

    assert_pc_reset_R1: assert property (@(posedge clk)
        rst |=> (pc_q == '0));

    assert_beq_target_R7: assert property (@(posedge clk) disable iff (rst)
        (cls == CLS_BRANCH && rd_a == rd_b) |=> (pc_q == $past(br_target)));

    assert_beq_fall_R7: assert property (@(posedge clk) disable iff (rst)
        (cls == CLS_BRANCH && rd_a != rd_b) |=> (pc_q == $past(pc_q) + 32'd4));

    assert_jump_target_R8: assert property (@(posedge clk) disable iff (rst)
        (cls == CLS_JUMP) |=> (pc_q[27:2] == $past(instr[25:0])));

    assert_no_r0_commit_R9: assert property (@(posedge clk) disable iff (rst)
        wb_en_o |-> (wb_idx_o != 5'd0));

    assert_nop_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        (cls == CLS_NOP) |-> (!wb_en_o && !st_en_o));

    assert_store_only_sw_R6: assert property (@(posedge clk) disable iff (rst)
        st_en_o |-> (cls == CLS_STORE && !wb_en_o));
endmodule

// File: tb/test_onecyc_core.sv
`timescale 1ns/1ps
module test_onecyc_core;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ld_en = 1'b0, ld_dmem = 1'b0;
    logic [31:0] ld_addr = '0, ld_data = '0;
    logic [31:0] pc_o, wb_val_o, st_addr_o, st_val_o;
    logic        wb_en_o, st_en_o;
    logic [4:0]  wb_idx_o;

    always #2.5 clk = ~clk;

    onecyc_core i_onecyc_core (
        .clk(clk), .rst(rst), .ld_en(ld_en), .ld_dmem(ld_dmem),
        .ld_addr(ld_addr), .ld_data(ld_data), .pc_o(pc_o),
        .wb_en_o(wb_en_o), .wb_idx_o(wb_idx_o), .wb_val_o(wb_val_o),
        .st_en_o(st_en_o), .st_addr_o(st_addr_o), .st_val_o(st_val_o)
    );

    typedef struct {
        bit          is_st;
        int unsigned idx;
        logic [31:0] val;
        string       req;
    } exp_t;

    exp_t sb[$];
    int n_cmp = 0, n_bad = 0;
    bit armed = 0, done = 0;

    // R2 encodings
    function automatic logic [31:0] rins(int rd, int rs, int rt, int sh, logic [5:0] fn);
        return {6'b000000, rs[4:0], rt[4:0], rd[4:0], sh[4:0], fn};
    endfunction
    function automatic logic [31:0] iins(logic [5:0] op, int rs, int rt, logic [15:0] imm);
        return {op, rs[4:0], rt[4:0], imm};
    endfunction
    function automatic logic [31:0] jins(int idx);
        return {6'b000010, idx[25:0]};
    endfunction

    task automatic load(bit d, int a, logic [31:0] v);   // R12
        ld_en = 1'b1; ld_dmem = d; ld_addr = a; ld_data = v;
        @(posedge clk); #1;
        ld_en = 1'b0;
    endtask

    task automatic put(int a, logic [31:0] ins);
        load(1'b0, a, ins);
    endtask

    task automatic exp_wb(int idx, logic [31:0] v, string req);
        exp_t e; e.is_st = 0; e.idx = idx; e.val = v; e.req = req;
        sb.push_back(e);
    endtask

    task automatic exp_st(int addr, logic [31:0] v, string req);
        exp_t e; e.is_st = 1; e.idx = addr; e.val = v; e.req = req;
        sb.push_back(e);
    endtask

    task automatic check(bit c, string req, logic [31:0] act, logic [31:0] expv);
        n_cmp++;
        if (!c) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic take(bit is_st, int unsigned idx, logic [31:0] v);
        exp_t e;
        n_cmp++;
        if (sb.size() == 0) begin
            n_bad++;
            $display("FAIL R11 unexpected %s idx=%0d val=%h expected=none",
                     is_st ? "store" : "writeback", idx, v);
        end else begin
            e = sb.pop_front();
            if (e.is_st != is_st || e.idx != idx || e.val !== v) begin
                n_bad++;
                $display("FAIL %s actual=%s %0d/%h expected=%s %0d/%h", e.req,
                         is_st ? "st" : "wb", idx, v, e.is_st ? "st" : "wb", e.idx, e.val);
            end
        end
    endtask

    // Monitor: compare retired effects against the scoreboard
    always @(negedge clk) begin
        if (armed && !rst) begin
            if (wb_en_o) take(1'b0, wb_idx_o, wb_val_o);
            if (st_en_o) take(1'b1, st_addr_o, st_val_o);
        end
    end

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        logic [31:0] pc_a;
        @(posedge clk); #1;
        load(1'b1, 0, 32'd7);            // R12 data memory
        load(1'b1, 1, 32'hFFFF_FFFD);
        put(0,  iins(6'b100011, 0, 1, 16'd0));        exp_wb(1, 32'd7, "R5 lw r1");
        put(1,  iins(6'b100011, 0, 2, 16'd4));        exp_wb(2, 32'hFFFF_FFFD, "R5 lw r2");
        put(2,  rins(3, 1, 2, 5, 6'b100000));         exp_wb(3, 32'd4, "R3 add shamt ignored");
        put(3,  rins(4, 2, 1, 0, 6'b100010));         exp_wb(4, 32'hFFFF_FFF6, "R3 sub");
        put(4,  rins(5, 1, 2, 0, 6'b100100));         exp_wb(5, 32'd5, "R3 and");
        put(5,  rins(6, 1, 2, 0, 6'b100101));         exp_wb(6, 32'hFFFF_FFFF, "R3 or");
        put(6,  rins(7, 2, 1, 0, 6'b101010));         exp_wb(7, 32'd1, "R4 slt neg<pos");
        put(7,  rins(8, 1, 2, 0, 6'b101010));         exp_wb(8, 32'd0, "R4 slt pos<neg");
        put(8,  rins(0, 1, 1, 0, 6'b100000));         // R9 write to r0 dropped
        put(9,  rins(9, 0, 1, 0, 6'b100000));         exp_wb(9, 32'd7, "R9 r0 reads zero");
        put(10, iins(6'b101011, 0, 3, 16'd8));        exp_st(8, 32'd4, "R6 sw");
        put(11, iins(6'b100011, 0, 10, 16'd8));       exp_wb(10, 32'd4, "R5 lw after sw");
        put(12, iins(6'b000100, 1, 9, 16'd2));        // R7 taken forward
        put(13, rins(12, 1, 1, 0, 6'b100000));        // shadow
        put(14, rins(12, 1, 1, 0, 6'b100000));        // shadow
        put(15, iins(6'b000100, 1, 2, 16'd5));        // R7 not taken
        put(16, rins(13, 3, 3, 0, 6'b100000));        exp_wb(13, 32'd8, "R7 fall-through");
        put(17, jins(20));                            // R8 jump
        put(18, rins(14, 1, 1, 0, 6'b100000));        // shadow
        put(19, rins(14, 1, 1, 0, 6'b100000));        // shadow
        put(20, rins(15, 13, 1, 0, 6'b100000));       exp_wb(15, 32'd15, "R8 jump target");
        put(21, iins(6'b000100, 0, 0, 16'd1));        // R7 taken r0==r0
        put(22, rins(14, 1, 1, 0, 6'b100000));        // shadow
        put(23, iins(6'b101011, 13, 15, 16'hFFFC));   exp_st(4, 32'd15, "R6 sw neg disp");
        put(24, iins(6'b100011, 0, 16, 16'd4));       exp_wb(16, 32'd15, "R5 lw stored word");
        put(25, iins(6'b001000, 1, 17, 16'd5));       // R10 unknown opcode
        put(26, iins(6'b000100, 0, 0, 16'hFFFF));     // R7 backward self-branch
        @(negedge clk);
        check(pc_o == 0 && !wb_en_o && !st_en_o, "R1 reset quiet", pc_o, 32'd0);
        @(posedge clk); #1;
        armed = 1;
        rst = 1'b0;
        repeat (60) @(posedge clk);
        #1;
        pc_a = pc_o;
        check(pc_o == 32'd104, "R7 backward branch halt pc", pc_o, 32'd104);
        @(posedge clk); #1;
        check(pc_o == pc_a, "R10 pc stable in loop", pc_o, pc_a);
        check(sb.size() == 0, "R11 all events seen", sb.size(), 32'd0);
        done = 1;
        summary();
        $finish;
    end

    initial begin
        #(5.0 * 5000);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL R1 watchdog actual=hung expected=finished");
            summary();
            $finish;
        end
    end
endmodule